// File: doc/BRIEF.md
# Ring-Chained Deep FIFO

This block builds one deep first-in first-out buffer out of several identical slices. Each slice is a small FIFO with its own storage, pointers and status flags. Only one slice at a time may accept writes, and only one slice at a time may supply reads. That right is a token passed around a ring. When a slice fills its top storage word, it raises a one-cycle write hand-off pulse toward the next slice. When it drains its top word, it raises a read hand-off pulse in the same way. No central address decoder is needed: the shared write data, read data and enable lines go to every slice, and the tokens alone decide which slice acts.

One slice has its strap tied low. It starts with both tokens. The others are strapped high and start idle. The hand-off outputs feed the next slice's inputs, and the last slice feeds the first. Per-slice status flags are active low. The top ORs them into composite flags, so a composite flag asserts only when every slice asserts its own. A half-full indication has no meaning in this arrangement and is not provided. The whole ring runs on one clock.

Top module: `fifo_ring`

## Requirements
- R1: While `rstN` is low at a rising edge, the block empties. After reset, `emptyN`=0, `fullN`=1, `almostEmptyN`=0 and `almostFullN`=1, and `rdData` is all zeros.
- R2: After reset, only slice 0 (strap low) holds the write token and the read token. The first word written is the first word read. At all times exactly one slice holds each token.
- R3: Writing the last storage word of a slice pulses that slice's write hand-off output for one cycle. The next slice in the ring holds the write token from that clock edge on, and the last slice hands over to slice 0.
- R4: Reading the last storage word of a slice pulses its read hand-off output for one cycle. The next slice in the ring holds the read token from that clock edge on, with the same wrap from last to first.
- R5: Words come out in the order they were written, including across slice boundaries and around the ring.
- R6: With the FIFO empty, `rdEn` is ignored. `rdData` keeps the last word read, and no flag changes.
- R7: With the FIFO full (`NUM_SLICES*SLICE_DEPTH` words), `wrEn` is ignored. The dropped word never appears on a later read.
- R8: A read accepted at a rising edge shows its word on `rdData` right after that edge.
- R9: With `outEn` low, `rdData` is all zeros. With `outEn` high, only the slice that supplied the most recent word drives `rdData`.
- R10: `emptyN` is the OR of the per-slice active-low empty flags, so it is 0 only when the whole FIFO is empty. `fullN` is the OR of the per-slice full flags, so it is 0 only when all slices are full.
- R11: `almostEmptyN` is 0 exactly when every slice holds at most `AE_LEVEL` words. `almostFullN` is 0 exactly when every slice holds at least `SLICE_DEPTH-AF_LEVEL` words.
- R12: A read and a write in the same cycle both take effect, with two exceptions. When full, the write is refused even with a read in that cycle. When empty, the read is refused even with a write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all slices |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write request on the shared bus |
| wrData | input | DATA_W | Shared write data |
| rdEn | input | 1 | Read request on the shared bus |
| outEn | input | 1 | Output enable for the read data bus |
| rdData | output | DATA_W | Shared, registered read data |
| emptyN | output | 1 | Composite empty flag, active low |
| fullN | output | 1 | Composite full flag, active low |
| almostEmptyN | output | 1 | Composite almost-empty flag, active low |
| almostFullN | output | 1 | Composite almost-full flag, active low |

## Verification
The assertions assume one clock shared by every slice and reset held low for at least one rising edge before traffic starts. They also assume the enables and write data are settled around each edge, so the token and hand-off relations can be checked one cycle apart. The stimulus changes every input on the falling edge and samples on the next falling edge. Reset is asserted with `wrEn` and `rdEn` low, so no request lands while the ring is re-seeding its tokens.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;
  // strobes from a slice's control to its storage
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } sliceStb_t;
endpackage

// File: rtl/fifo_ring_ctrl.sv
module fifo_ring_ctrl
  import fifo_ring_pkg::*;
#(
  parameter int SLICE_DEPTH = 4,
  parameter int AE_LEVEL    = 1,
  parameter int AF_LEVEL    = 1,
  localparam int AW = $clog2(SLICE_DEPTH),
  localparam int CW = $clog2(SLICE_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          strapN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          anyRead,
  input  logic          wxi,
  input  logic          rxi,
  output logic          wxo,
  output logic          rxo,
  output logic          wrTok,
  output logic          rdTok,
  output logic          driveOut,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output sliceStb_t     stb,
  output logic          emptyN,
  output logic          fullN,
  output logic          almostEmptyN,
  output logic          almostFullN
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(SLICE_DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(SLICE_DEPTH);
  localparam logic [CW-1:0] AE_CNT    = CW'(AE_LEVEL);
  localparam logic [CW-1:0] AF_CNT    = CW'(SLICE_DEPTH - AF_LEVEL);

  logic [CW-1:0] cnt;
  logic isFull, isEmpty;

  assign isFull  = (cnt == FULL_CNT);
  assign isEmpty = (cnt == '0);

  assign stb.wrStb = wrEn && wrTok && !isFull;
  assign stb.rdStb = rdEn && rdTok && !isEmpty;
  assign wxo = stb.wrStb && (wrAddr == LAST_ADDR);
  assign rxo = stb.rdStb && (rdAddr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrTok    <= !strapN;
      rdTok    <= !strapN;
      driveOut <= !strapN;
      wrAddr   <= '0;
      rdAddr   <= '0;
      cnt      <= '0;
    end else begin
      if (wxi)      wrTok <= 1'b1;
      else if (wxo) wrTok <= 1'b0;
      if (rxi)      rdTok <= 1'b1;
      else if (rxo) rdTok <= 1'b0;
      if (stb.rdStb)    driveOut <= 1'b1;
      else if (anyRead) driveOut <= 1'b0;
      if (stb.wrStb) wrAddr <= (wrAddr == LAST_ADDR) ? '0 : wrAddr + 1'b1;
      if (stb.rdStb) rdAddr <= (rdAddr == LAST_ADDR) ? '0 : rdAddr + 1'b1;
      cnt <= cnt + CW'(stb.wrStb) - CW'(stb.rdStb);
    end
  end

  assign emptyN       = !isEmpty;
  assign fullN        = !isFull;
  assign almostEmptyN = !(cnt <= AE_CNT);
  assign almostFullN  = !(cnt >= AF_CNT);

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= FULL_CNT);
  a_r3_write_wrap: assert property (@(posedge clk) disable iff (!rstN)
    wxo |=> (wrAddr == '0));
  a_r4_read_wrap: assert property (@(posedge clk) disable iff (!rstN)
    rxo |=> (rdAddr == '0));
  a_r6_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && !wrEn) |=> isEmpty);
endmodule

// File: rtl/fifo_ring_data.sv
module fifo_ring_data
  import fifo_ring_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SLICE_DEPTH = 4,
  localparam int AW = $clog2(SLICE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sliceStb_t         stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] store [SLICE_DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wrStb) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          q <= '0;
    else if (stb.rdStb) q <= store[rdAddr];
  end
endmodule

// File: rtl/fifo_ring.sv
module fifo_ring
  import fifo_ring_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_SLICES  = 3,
  parameter int SLICE_DEPTH = 4,
  parameter int AE_LEVEL    = 1,
  parameter int AF_LEVEL    = 1,
  localparam int AW = $clog2(SLICE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              outEn,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyN,
  output logic              fullN,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  logic [NUM_SLICES-1:0] wxoV, rxoV, wrTokV, rdTokV, driveV, rdStbV;
  logic [NUM_SLICES-1:0] emptyV, fullV, aeV, afV;
  logic [DATA_W-1:0]     qArr [NUM_SLICES];
  logic                  anyRead;

  assign anyRead = |rdStbV;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam int PREV = (i == 0) ? NUM_SLICES - 1 : i - 1;
    localparam int NEXT = (i == NUM_SLICES - 1) ? 0 : i + 1;
    sliceStb_t     stb;
    logic [AW-1:0] wrAddr, rdAddr;

    fifo_ring_ctrl #(.SLICE_DEPTH(SLICE_DEPTH), .AE_LEVEL(AE_LEVEL),
                     .AF_LEVEL(AF_LEVEL)) u_ctrl (
      .clk(clk), .rstN(rstN), .strapN((i == 0) ? 1'b0 : 1'b1),
      .wrEn(wrEn), .rdEn(rdEn), .anyRead(anyRead),
      .wxi(wxoV[PREV]), .rxi(rxoV[PREV]), .wxo(wxoV[i]), .rxo(rxoV[i]),
      .wrTok(wrTokV[i]), .rdTok(rdTokV[i]), .driveOut(driveV[i]),
      .wrAddr(wrAddr), .rdAddr(rdAddr), .stb(stb),
      .emptyN(emptyV[i]), .fullN(fullV[i]),
      .almostEmptyN(aeV[i]), .almostFullN(afV[i])
    );

    fifo_ring_data #(.DATA_W(DATA_W), .SLICE_DEPTH(SLICE_DEPTH)) u_data (
      .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
      .wrData(wrData), .q(qArr[i])
    );

    assign rdStbV[i] = stb.rdStb;

    a_r3_write_handover: assert property (@(posedge clk) disable iff (!rstN)
      wxoV[i] |=> wrTokV[NEXT]);
    a_r4_read_handover: assert property (@(posedge clk) disable iff (!rstN)
      rxoV[i] |=> rdTokV[NEXT]);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_SLICES; i++)
      if (outEn && driveV[i]) rdData = rdData | qArr[i];
  end

  assign emptyN       = |emptyV;
  assign fullN        = |fullV;
  assign almostEmptyN = |aeV;
  assign almostFullN  = |afV;

  a_r2_one_write_token: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(wrTokV));
  a_r2_one_read_token: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(rdTokV));
  a_r9_one_driver: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(driveV));
  a_r12_single_reader: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdStbV));
endmodule

// File: tb/fifo_ring_test.sv
module fifo_ring_test;
  localparam int W = 8, N = 3, D = 4, AE = 1, AF = 1, CAP = N * D;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, outEn = 1'b1;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic emptyN, fullN, almostEmptyN, almostFullN;

  fifo_ring #(.DATA_W(W), .NUM_SLICES(N), .SLICE_DEPTH(D),
              .AE_LEVEL(AE), .AF_LEVEL(AF)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .outEn(outEn), .rdData(rdData), .emptyN(emptyN), .fullN(fullN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int mq[$];
  int rdG = 0;
  logic [W-1:0] lastOut = '0;

  // wr, rd, oe, data
  localparam logic [10:0] VEC [24] = '{
    {3'b101, 8'h11}, {3'b101, 8'h22}, {3'b101, 8'h33}, {3'b101, 8'h44},
    {3'b101, 8'h55}, {3'b111, 8'h66}, {3'b011, 8'h00}, {3'b010, 8'h00},
    {3'b001, 8'h00}, {3'b111, 8'h77}, {3'b011, 8'h00}, {3'b011, 8'h00},
    {3'b011, 8'h00}, {3'b011, 8'h00}, {3'b011, 8'h00}, {3'b101, 8'h88},
    {3'b111, 8'h99}, {3'b011, 8'h00}, {3'b011, 8'h00}, {3'b011, 8'h00},
    {3'b100, 8'hAA}, {3'b100, 8'hBB}, {3'b011, 8'h00}, {3'b001, 8'h00}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    int sc [N];
    bit allAe, allAf;
    foreach (sc[k]) sc[k] = 0;
    for (int k = 0; k < mq.size(); k++) sc[((rdG + k) % CAP) / D]++;
    allAe = 1; allAf = 1;
    foreach (sc[k]) begin
      if (sc[k] > AE) allAe = 0;
      if (sc[k] < D - AF) allAf = 0;
    end
    chk({tag, " R5/R9 rdData"}, rdData, outEn ? lastOut : 0);
    chk({tag, " R10 emptyN"}, emptyN, mq.size() != 0);
    chk({tag, " R10 fullN"}, fullN, mq.size() != CAP);
    chk({tag, " R11 almostEmptyN"}, almostEmptyN, !allAe);
    chk({tag, " R11 almostFullN"}, almostFullN, !allAf);
  endtask

  task automatic step(input logic wr, input logic rd, input logic oe,
                      input logic [W-1:0] d, input string tag);
    int pre;
    wrEn = wr; rdEn = rd; outEn = oe; wrData = d;
    @(posedge clk);
    @(negedge clk);
    pre = mq.size();
    if (rd && pre > 0) begin
      lastOut = W'(mq.pop_front());
      rdG = (rdG + 1) % CAP;
    end
    if (wr && pre < CAP) mq.push_back(int'(d));
    checkAll(tag);
  endtask

  task automatic doReset();
    wrEn = 0; rdEn = 0; outEn = 1; rstN = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1;
    mq.delete(); rdG = 0; lastOut = '0;
    chk("R1 rdData", rdData, 0);
    chk("R1 emptyN", emptyN, 0);
    chk("R1 fullN", fullN, 1);
    chk("R1 almostEmptyN", almostEmptyN, 0);
    chk("R1 almostFullN", almostFullN, 1);
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // table: R2 first word, R3/R4 boundary crossing, R6, R8, R9, R12
    for (int v = 0; v < 24; v++)
      step(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0], $sformatf("vec%0d", v));

    // R1 again, then fill to full: R7 overflow ignored, R12 write refused at full
    doReset();
    for (int k = 0; k < CAP; k++) step(1, 0, 1, W'(8'hA0 + k), "fill R3");
    step(1, 0, 1, 8'hEE, "overflow R7");
    step(1, 1, 1, 8'hEF, "full rw R12");
    for (int k = 0; k < CAP - 1; k++) step(0, 1, 1, '0, "drain R4 R5");
    step(0, 1, 1, '0, "empty read R6");
    step(1, 1, 1, 8'h5A, "empty rw R12");
    step(0, 1, 0, '0, "oe low R9");
    // ring wrap: last slice hands to slice 0 (R3, R4)
    for (int k = 0; k < 10; k++) step(1, 0, 1, W'(8'h30 + k), "wrap wr R3");
    for (int k = 0; k < 6; k++) step(1, 1, 1, W'(8'h60 + k), "wrap rw R12");
    for (int k = 0; k < 11; k++) step(0, 1, 1, '0, "wrap rd R4 R5");
    step(0, 0, 1, '0, "idle R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule